// File: doc/BRIEF.md
# Dual-channel split/concatenated interval timer

This block is a register-programmed timer with two channels, A and B. In split mode each channel is an independent 16-bit counter that advances on the tick of its own 8-bit prescaler. In concatenated mode, channel A becomes a single 32-bit counter that steps on every clock with the prescaler bypassed, and channel B is frozen. Each channel counts either down from its load value to zero or up from zero to its load value. On reaching that terminal count it reloads and keeps running.

Software programs the block through a single-cycle write port and a combinational read port addressed by a 4-bit word index. A channel can raise a match event when its counter value equals its match register. Match events collect in a raw status register. A mask register selects which raw bits reach the masked status. Each channel drives its own interrupt line.

Register map (word index: meaning):

- 0: mode select; bit 0 set means 32-bit mode.
- 1: run control; bit 0 enables A, bit 1 enables B.
- 2 and 3: channel setup for A and B; bit 0 selects up-counting, bit 1 enables the match event.
- 4 and 5: load values for A and B.
- 6 and 7: match values for A and B.
- 8 and 9: prescaler values for A and B.
- 10: mask.
- 11: raw status.
- 12: masked status.
- 13: clear register, write-only; reads return 0.
- 14 and 15: counter values of A and B.

Top module: `gp_timer`

## Requirements
- R1: After reset, the mode select reads 0 (split mode), raw status reads 0, both interrupt lines are low, and the channel A counter reads 0xFFFF.
- R2: In split mode, a channel with prescaler value N (register bits 7:0) advances once every N+1 clocks while enabled. Counting starts N+1 clocks after the enable takes effect.
- R3: With setup bit 0 clear, a channel counts down from its load value L. After reaching 0 it returns to L, so after T steps it reads L - (T mod (L+1)).
- R4: With setup bit 0 set, a channel counts up from 0. After reaching L it returns to 0, so after T steps it reads T mod (L+1).
- R5: With mode select bit 0 set, channel A counts over 32 bits and advances on every enabled clock whatever its prescaler holds. Channel B does not change, even when its enable is set.
- R6: A channel whose enable bit is clear keeps its counter value.
- R7: A step taken while a channel's counter equals its match value sets that channel's raw flag, provided setup bit 1 is set. Channel A uses raw status bit 4 and channel B uses bit 12. With setup bit 1 clear, no flag is set.
- R8: Masked status equals raw status AND mask. irq_a is the OR of masked bits 7:0 and irq_b is the OR of masked bits 15:8.
- R9: Writing the clear register clears every raw flag whose data bit is 1. Bits written as 0 leave their flags unchanged.
- R10: A write to the mode select is ignored while either enable bit is set.
- R11: Writing a channel's load, setup or prescaler register restarts that channel on the next clock (to L when counting down, to 0 when counting up) and restarts its prescaler. An accepted mode-select write restarts both channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one register per cycle |
| bus_addr | input | 4 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_a | output | 1 | Channel A interrupt |
| irq_b | output | 1 | Channel B interrupt |

## Verification
The properties assume a single write per cycle on a well-formed bus. They also assume that software changes a channel's load, setup or prescaler only through the bus, so every such change carries the restart pulse the wrap and step properties exclude. The stimulus keeps to this by clearing both enables before it reprograms a channel. It runs a channel only by setting and then clearing an enable, and it reads state only while both channels are stopped. The exact tick counts the bench predicts therefore follow from the enable window alone. Load values stay small in split mode so that wraps occur within short runs, and the 32-bit runs start just above the 16-bit boundary so that a 16-bit counter would read a different value.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

    localparam int ADDR_W     = 4;
    localparam int STAT_W     = 16;
    localparam int FLAG_A_BIT = 4;
    localparam int FLAG_B_BIT = 12;

    typedef enum logic [ADDR_W-1:0] {
        RG_CFG    = 4'd0,
        RG_CTRL   = 4'd1,
        RG_MODE_A = 4'd2,
        RG_MODE_B = 4'd3,
        RG_LOAD_A = 4'd4,
        RG_LOAD_B = 4'd5,
        RG_MTCH_A = 4'd6,
        RG_MTCH_B = 4'd7,
        RG_PRE_A  = 4'd8,
        RG_PRE_B  = 4'd9,
        RG_MASK   = 4'd10,
        RG_RAW    = 4'd11,
        RG_MSKD   = 4'd12,
        RG_CLR    = 4'd13,
        RG_CNT_A  = 4'd14,
        RG_CNT_B  = 4'd15
    } reg_addr_e;

    // channel setup register: bit1 match event enable, bit0 count up
    typedef struct packed {
        logic match_ie;
        logic count_up;
    } chan_mode_t;

    typedef struct packed {
        logic en_b;
        logic en_a;
    } run_ctrl_t;

    function automatic logic bus_hit(input logic wr, input logic [ADDR_W-1:0] addr,
                                     input reg_addr_e which);
        return wr && (addr == which);
    endfunction

endpackage

// File: rtl/gpt_prescale.sv
module gpt_prescale #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             bypass,
    input  logic             restart,
    input  logic [PRE_W-1:0] div,
    output logic             tick
);
    logic [PRE_W-1:0] phase;

    assign tick = run && (bypass || (phase == div));

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase <= '0;
        end else if (run) begin
            phase <= tick ? '0 : phase + PRE_W'(1);
        end
    end
endmodule

// File: rtl/gpt_counter.sv
module gpt_counter #(
    parameter int           W       = 16,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         reload,
    input  logic         step,
    input  logic         up,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] match_val,
    output logic [W-1:0] cnt,
    output logic         hit
);
    logic [W-1:0] start_val;
    logic [W-1:0] term_val;

    assign start_val = up ? '0 : load_val;
    assign term_val  = up ? load_val : '0;
    assign hit       = step && !reload && (cnt == match_val);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= RST_VAL;
        end else if (reload) begin
            cnt <= start_val;
        end else if (step) begin
            if (cnt == term_val) cnt <= start_val;
            else if (up)         cnt <= cnt + W'(1);
            else                 cnt <= cnt - W'(1);
        end
    end
endmodule

// File: rtl/gpt_irq.sv
module gpt_irq #(
    parameter int SW    = 16,
    parameter int A_BIT = 4,
    parameter int B_BIT = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          set_a,
    input  logic          set_b,
    input  logic          mask_wr,
    input  logic          clr_wr,
    input  logic [SW-1:0] wdata,
    output logic [SW-1:0] ris,
    output logic [SW-1:0] mask,
    output logic [SW-1:0] mis,
    output logic          irq_a,
    output logic          irq_b
);
    localparam int HALF = SW / 2;

    logic [SW-1:0] set_vec;
    logic [SW-1:0] clr_vec;

    assign set_vec = (SW'(set_a) << A_BIT) | (SW'(set_b) << B_BIT);
    assign clr_vec = clr_wr ? wdata : '0;
    assign mis     = ris & mask;
    assign irq_a   = |mis[HALF-1:0];
    assign irq_b   = |mis[SW-1:HALF];

    always_ff @(posedge clk) begin
        if (rst) begin
            ris  <= '0;
            mask <= '0;
        end else begin
            // a new event wins over a clear in the same cycle
            ris <= (ris & ~clr_vec) | set_vec;
            if (mask_wr) mask <= wdata;
        end
    end
endmodule

// File: rtl/gp_timer.sv
module gp_timer import gpt_pkg::*; #(
    parameter int CNT_W = 32,
    parameter int PRE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq_a,
    output logic              irq_b
);
    localparam int HALF_W = CNT_W / 2;
    localparam logic [CNT_W-1:0]  A_RST = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
    localparam logic [HALF_W-1:0] B_RST = '1;

    logic              cfg_wide;
    run_ctrl_t         ctrl_q;
    chan_mode_t        mode_a, mode_b;
    logic [CNT_W-1:0]  load_a, match_a;
    logic [HALF_W-1:0] load_b, match_b;
    logic [PRE_W-1:0]  pre_a, pre_b;

    logic cfg_ok, a_restart, b_restart, a_reload, b_reload;
    logic a_tick, b_tick, a_hit, b_hit, set_a, set_b, a_up;
    logic [CNT_W-1:0]  a_cnt, a_load_eff, a_match_eff;
    logic [HALF_W-1:0] b_cnt;
    logic [STAT_W-1:0] ris_q, mask_q, mis_q;

    assign cfg_ok    = bus_hit(bus_wr, bus_addr, RG_CFG) && (ctrl_q == '0);
    assign a_restart = cfg_ok || bus_hit(bus_wr, bus_addr, RG_MODE_A) ||
                       bus_hit(bus_wr, bus_addr, RG_LOAD_A) || bus_hit(bus_wr, bus_addr, RG_PRE_A);
    assign b_restart = cfg_ok || bus_hit(bus_wr, bus_addr, RG_MODE_B) ||
                       bus_hit(bus_wr, bus_addr, RG_LOAD_B) || bus_hit(bus_wr, bus_addr, RG_PRE_B);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_wide <= 1'b0;
            ctrl_q   <= '0;
            mode_a   <= '0;
            mode_b   <= '0;
            load_a   <= '1;
            load_b   <= '1;
            match_a  <= '0;
            match_b  <= '0;
            pre_a    <= '0;
            pre_b    <= '0;
            a_reload <= 1'b0;
            b_reload <= 1'b0;
        end else begin
            // restart one clock later so the counter sees the new register values
            a_reload <= a_restart;
            b_reload <= b_restart;
            if (cfg_ok) cfg_wide <= bus_wdata[0];
            if (bus_hit(bus_wr, bus_addr, RG_CTRL))   ctrl_q  <= run_ctrl_t'(bus_wdata[1:0]);
            if (bus_hit(bus_wr, bus_addr, RG_MODE_A)) mode_a  <= chan_mode_t'(bus_wdata[1:0]);
            if (bus_hit(bus_wr, bus_addr, RG_MODE_B)) mode_b  <= chan_mode_t'(bus_wdata[1:0]);
            if (bus_hit(bus_wr, bus_addr, RG_LOAD_A)) load_a  <= bus_wdata;
            if (bus_hit(bus_wr, bus_addr, RG_LOAD_B)) load_b  <= bus_wdata[HALF_W-1:0];
            if (bus_hit(bus_wr, bus_addr, RG_MTCH_A)) match_a <= bus_wdata;
            if (bus_hit(bus_wr, bus_addr, RG_MTCH_B)) match_b <= bus_wdata[HALF_W-1:0];
            if (bus_hit(bus_wr, bus_addr, RG_PRE_A))  pre_a   <= bus_wdata[PRE_W-1:0];
            if (bus_hit(bus_wr, bus_addr, RG_PRE_B))  pre_b   <= bus_wdata[PRE_W-1:0];
        end
    end

    assign a_up        = mode_a.count_up;
    assign a_load_eff  = cfg_wide ? load_a  : CNT_W'(load_a[HALF_W-1:0]);
    assign a_match_eff = cfg_wide ? match_a : CNT_W'(match_a[HALF_W-1:0]);

    gpt_prescale #(.PRE_W(PRE_W)) u_pre_a (
        .clk(clk), .rst(rst), .run(ctrl_q.en_a), .bypass(cfg_wide),
        .restart(a_reload), .div(pre_a), .tick(a_tick)
    );

    gpt_prescale #(.PRE_W(PRE_W)) u_pre_b (
        .clk(clk), .rst(rst), .run(ctrl_q.en_b && !cfg_wide), .bypass(1'b0),
        .restart(b_reload), .div(pre_b), .tick(b_tick)
    );

    gpt_counter #(.W(CNT_W), .RST_VAL(A_RST)) u_cnt_a (
        .clk(clk), .rst(rst), .reload(a_reload), .step(a_tick), .up(a_up),
        .load_val(a_load_eff), .match_val(a_match_eff), .cnt(a_cnt), .hit(a_hit)
    );

    gpt_counter #(.W(HALF_W), .RST_VAL(B_RST)) u_cnt_b (
        .clk(clk), .rst(rst), .reload(b_reload), .step(b_tick), .up(mode_b.count_up),
        .load_val(load_b), .match_val(match_b), .cnt(b_cnt), .hit(b_hit)
    );

    assign set_a = a_hit && mode_a.match_ie;
    assign set_b = b_hit && mode_b.match_ie;

    gpt_irq #(.SW(STAT_W), .A_BIT(FLAG_A_BIT), .B_BIT(FLAG_B_BIT)) u_irq (
        .clk(clk), .rst(rst), .set_a(set_a), .set_b(set_b),
        .mask_wr(bus_hit(bus_wr, bus_addr, RG_MASK)),
        .clr_wr(bus_hit(bus_wr, bus_addr, RG_CLR)),
        .wdata(bus_wdata[STAT_W-1:0]),
        .ris(ris_q), .mask(mask_q), .mis(mis_q), .irq_a(irq_a), .irq_b(irq_b)
    );

    always_comb begin
        unique case (reg_addr_e'(bus_addr))
            RG_CFG:    bus_rdata = CNT_W'(cfg_wide);
            RG_CTRL:   bus_rdata = CNT_W'(ctrl_q);
            RG_MODE_A: bus_rdata = CNT_W'(mode_a);
            RG_MODE_B: bus_rdata = CNT_W'(mode_b);
            RG_LOAD_A: bus_rdata = load_a;
            RG_LOAD_B: bus_rdata = CNT_W'(load_b);
            RG_MTCH_A: bus_rdata = match_a;
            RG_MTCH_B: bus_rdata = CNT_W'(match_b);
            RG_PRE_A:  bus_rdata = CNT_W'(pre_a);
            RG_PRE_B:  bus_rdata = CNT_W'(pre_b);
            RG_MASK:   bus_rdata = CNT_W'(mask_q);
            RG_RAW:    bus_rdata = CNT_W'(ris_q);
            RG_MSKD:   bus_rdata = CNT_W'(mis_q);
            RG_CLR:    bus_rdata = '0;
            RG_CNT_A:  bus_rdata = a_cnt;
            RG_CNT_B:  bus_rdata = CNT_W'(b_cnt);
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpt_checker.sv
module gpt_checker #(
    parameter int CNT_W  = 32,
    parameter int HALF_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [3:0]        bus_addr,
    input logic [CNT_W-1:0]  bus_wdata,
    input logic              irq_b,
    input logic              cfg_wide,
    input logic [1:0]        ctrl_q,
    input logic [CNT_W-1:0]  a_cnt,
    input logic [HALF_W-1:0] b_cnt,
    input logic              a_tick,
    input logic              a_reload,
    input logic              b_reload,
    input logic              a_up,
    input logic [CNT_W-1:0]  a_load_eff,
    input logic              set_a,
    input logic [15:0]       ris_q
);
    // R6: a stopped channel holds its count
    p_hold_a_r6: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q[0] && !a_reload) |=> $stable(a_cnt));

    // R5: channel B is frozen in 32-bit mode
    p_b_frozen_r5: assert property (@(posedge clk) disable iff (rst)
        (cfg_wide && !b_reload) |=> $stable(b_cnt));

    // R3: a down-counting channel wraps from zero to its load value
    p_down_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (a_tick && !a_reload && !a_up && a_cnt == '0) |=> (a_cnt == $past(a_load_eff)));

    // R4: an up-counting channel below its load steps by one
    p_up_step_r4: assert property (@(posedge clk) disable iff (rst)
        (a_tick && !a_reload && a_up && a_cnt != a_load_eff) |=> (a_cnt == $past(a_cnt) + CNT_W'(1)));

    // R7: a match event shows up in raw status
    p_flag_set_r7: assert property (@(posedge clk) disable iff (rst)
        set_a |=> ris_q[4]);

    // R9: write-1 clears the flag when no new event arrives
    p_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 4'd13 && bus_wdata[4] && !set_a) |=> !ris_q[4]);

    // R10: mode select is locked while a channel runs
    p_cfg_lock_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 4'd0 && ctrl_q != 2'b00) |=> $stable(cfg_wide));

    // R8: only bit 12 feeds the upper half, so irq_b needs that raw flag
    p_irq_b_r8: assert property (@(posedge clk) disable iff (rst)
        irq_b |-> ris_q[12]);
endmodule

bind gp_timer gpt_checker #(.CNT_W(CNT_W), .HALF_W(HALF_W)) u_chk (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .irq_b(irq_b), .cfg_wide(cfg_wide), .ctrl_q(ctrl_q), .a_cnt(a_cnt), .b_cnt(b_cnt),
    .a_tick(a_tick), .a_reload(a_reload), .b_reload(b_reload), .a_up(a_up),
    .a_load_eff(a_load_eff), .set_a(set_a), .ris_q(ris_q)
);

// File: tb/gp_timer_test.sv
`timescale 1ns/1ps
module gp_timer_test;
    localparam int A_CFG = 0, A_CTRL = 1, A_MODEA = 2, A_MODEB = 3, A_LOADA = 4, A_LOADB = 5;
    localparam int A_MTA = 6, A_MTB = 7, A_PREA = 8, A_PREB = 9, A_MASK = 10, A_RAW = 11;
    localparam int A_MSKD = 12, A_CLR = 13, A_CNTA = 14, A_CNTB = 15;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_a, irq_b;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    gp_timer uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_a(irq_a), .irq_b(irq_b)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = 4'(a);
        #1 d = bus_rdata;
    endtask

    // enable for exactly m counting edges, then stop
    task automatic run(input logic [1:0] en, input int m);
        wr(A_CTRL, 32'(en));
        repeat (m - 1) @(posedge clk);
        wr(A_CTRL, 0);
    endtask

    task automatic setup_a(input int pre, input logic [31:0] load, input int mode, input logic [31:0] mt);
        wr(A_CTRL, 0);
        wr(A_PREA, pre);
        wr(A_MTA, mt);
        wr(A_LOADA, load);
        wr(A_MODEA, mode);
    endtask

    function automatic logic exp_hit(input logic up, input longint l, input longint m, input longint t);
        for (longint k = 0; k < t; k++) begin
            longint s = up ? (k % (l + 1)) : (l - (k % (l + 1)));
            if (s == m) return 1'b1;
        end
        return 1'b0;
    endfunction

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d, d2;
        int t;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        rd(A_CFG, d);  chk("R1 cfg", d, 0);
        rd(A_RAW, d);  chk("R1 raw", d, 0);
        rd(A_CNTA, d); chk("R1 cnt_a", d, 32'hFFFF);
        chk("R1 irq", {30'd0, irq_a, irq_b}, 0);

        // R2/R3 prescaler sweep, down count
        for (int n = 0; n < 6; n++) begin
            for (int mi = 0; mi < 4; mi++) begin
                int m = 1 + mi * 5;
                setup_a(n, 40, 0, 0);
                run(2'b01, m);
                t = m / (n + 1);
                rd(A_CNTA, d);
                chk($sformatf("R2 pre=%0d m=%0d", n, m), d, 32'(40 - (t % 41)));
            end
        end

        // R3 wrap through zero
        setup_a(0, 5, 0, 0);
        run(2'b01, 13);
        rd(A_CNTA, d); chk("R3 wrap", d, 32'(5 - (13 % 6)));

        // R4 up count sweep with prescaler 1
        for (int m = 1; m <= 25; m += 4) begin
            setup_a(1, 9, 1, 0);
            run(2'b01, m);
            rd(A_CNTA, d); chk($sformatf("R4 m=%0d", m), d, 32'((m / 2) % 10));
        end

        // R6 hold while stopped
        rd(A_CNTA, d);
        repeat (20) @(posedge clk);
        rd(A_CNTA, d2); chk("R6 hold", d2, d);

        // R7 no event with enable bit clear
        wr(A_CLR, 32'hFFFF);
        setup_a(0, 20, 0, 15);
        run(2'b01, 10);
        rd(A_RAW, d); chk("R7 ie off", d, 0);

        // R7 match sweep
        for (int m = 1; m <= 8; m++) begin
            wr(A_CLR, 32'hFFFF);
            setup_a(0, 20, 2, 15);
            run(2'b01, m);
            rd(A_RAW, d);
            chk($sformatf("R7 m=%0d", m), {31'd0, d[4]}, {31'd0, exp_hit(1'b0, 20, 15, m)});
        end

        // Channel B, up count, prescaler 2, match at 2; A must stay (R6)
        rd(A_CNTA, d2);
        wr(A_PREB, 2); wr(A_MTB, 2); wr(A_LOADB, 30); wr(A_MODEB, 3);
        run(2'b10, 9);
        rd(A_CNTB, d); chk("R4 chan_b", d, 3);
        rd(A_CNTA, d); chk("R6 a held during b", d, d2);
        rd(A_RAW, d);  chk("R7 both flags", d, 32'h1010);

        // R8 mask combinations
        wr(A_MASK, 32'h1000);
        rd(A_MSKD, d); chk("R8 mis b", d, 32'h1000);
        chk("R8 irq b only", {30'd0, irq_a, irq_b}, 32'b01);
        wr(A_MASK, 32'h0010);
        rd(A_MSKD, d); chk("R8 mis a", d, 32'h0010);
        chk("R8 irq a only", {30'd0, irq_a, irq_b}, 32'b10);
        wr(A_MASK, 0);
        chk("R8 irq none", {30'd0, irq_a, irq_b}, 0);

        // R9 write-1-to-clear
        wr(A_CLR, 0);
        rd(A_RAW, d); chk("R9 zero write", d, 32'h1010);
        wr(A_CLR, 32'h0010);
        rd(A_RAW, d); chk("R9 clear a", d, 32'h1000);

        // R11 restart on load and setup writes
        setup_a(0, 100, 0, 0);
        run(2'b01, 10);
        rd(A_CNTA, d); chk("R11 before", d, 90);
        wr(A_LOADA, 100);
        repeat (2) @(posedge clk);
        rd(A_CNTA, d); chk("R11 load restart", d, 100);
        wr(A_MODEA, 1);
        repeat (2) @(posedge clk);
        rd(A_CNTA, d); chk("R11 mode restart", d, 0);

        // R10 mode select locked while running
        wr(A_CTRL, 1);
        wr(A_CFG, 1);
        wr(A_CTRL, 0);
        rd(A_CFG, d); chk("R10 locked", d, 0);
        wr(A_CFG, 1);
        rd(A_CFG, d); chk("R10 accepted", d, 1);

        // R5 32-bit mode: prescaler ignored, crosses 16-bit boundary
        setup_a(7, 32'h0001_0002, 0, 0);
        rd(A_CNTB, d2);
        run(2'b11, 5);
        rd(A_CNTA, d); chk("R5 down 32", d, 32'h0000_FFFD);
        rd(A_CNTB, d); chk("R5 b frozen", d, d2);
        setup_a(7, 32'hFFFF_FFFF, 1, 0);
        run(2'b01, 100);
        rd(A_CNTA, d); chk("R5 up 32", d, 100);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule